// File: doc/BRIEF.md
# I2C Passive Bus Monitor

This block listens to an I2C bus through already synchronized and filtered SCL and SDA samples and records every byte that crosses it, whichever device sends it. It never drives SDA. Each byte is stored together with the level of the acknowledge bit that followed it. It also carries a tag telling whether the byte was the first one after a start on an idle bus or the first one after a repeated start.

The host side works through plain strobes. A read strobe consumes the captured word. Separate write-1-to-clear strobes drop the overrun and bus-idle flags. An enable input holds the whole block in its cleared state while low. A stretch-enable input selects the capture mode. With stretching off the monitor cannot be seen on the bus, and it reports an overrun when the host falls behind. With stretching on, the monitor holds SCL low through an open-drain pull-low output until the pending byte has been read, so that no byte is lost.

Top module: `i2c_bus_watch`

## Requirements
- R1: The captured word holds the byte in bits 7:0, received most significant bit first. Bit 8 is the start tag, bit 9 is the repeated-start tag and bit 10 is the not-acknowledged tag.
- R2: Bit 10 of the word is the SDA level sampled on the ninth rising SCL edge of the frame. A 1 means no receiver acknowledged the byte and a 0 means at least one receiver did.
- R3: `ready` rises when a byte is captured. It falls after a cycle with `rd_strobe` high and no new byte in that cycle. The word itself is kept after the read.
- R4: SDA falling while SCL is high is a start, and SDA rising while SCL is high is a stop. `bus_active` is high when a start has been seen more recently than a stop.
- R5: `idle_flag` is set when the bus goes from active to inactive. It then stays set until `clr_idle` is pulsed.
- R6: A byte captured while `ready` is still high, with no read in the same cycle, sets `overrun` and replaces the word. `clr_ovr` clears `overrun` and leaves `ready` as it is.
- R7: When `stretch_en` is high and a byte is unread, the block asserts `scl_pull_low` as soon as SCL is low and keeps it asserted until the byte is read. When `stretch_en` is low, `scl_pull_low` stays low.
- R8: While `enable` is low, `ready`, `overrun`, `idle_flag`, `bus_active`, the word and `scl_pull_low` are all cleared, and any partial frame is dropped.
- R9: A start on an idle bus tags the first byte completed after it with bit 8. A start while the bus is active tags that byte with bit 9. Later bytes in the same transfer carry neither tag.
- R10: A frame cut short by a start or a stop is thrown away, and bit counting restarts at the condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Monitor enable; low holds all state cleared |
| stretch_en | input | 1 | Selects lossless mode with SCL stretching |
| scl_in | input | 1 | Synchronized SCL level seen on the bus |
| sda_in | input | 1 | Synchronized SDA level seen on the bus |
| rd_strobe | input | 1 | Host read of the captured word; clears ready |
| clr_idle | input | 1 | Write-1-to-clear strobe for the idle flag |
| clr_ovr | input | 1 | Write-1-to-clear strobe for the overrun flag |
| rd_word | output | BYTE_W+3 | Captured byte with start, repeated-start and NACK tags |
| ready | output | 1 | A captured byte is waiting |
| overrun | output | 1 | Unread data was overwritten |
| bus_active | output | 1 | A start has been seen more recently than a stop |
| idle_flag | output | 1 | Sticky flag: the bus has returned to idle |
| scl_pull_low | output | 1 | Open-drain request to hold SCL low |

## Verification
The bench drives the bus as a master would, with a byte that is acknowledged, a byte that is not, a repeated start, and a frame that a stop cuts off after three bits. A design that misplaced the tags or copied them onto later bytes would show wrong bits 8 and 9 on the second and third bytes. A design that kept a partial frame would run the next byte in with stale bits and produce a wrong value. Two bytes are sent without a read in between. A missing overrun, or a second byte that fails to replace the first, shows up there, as does any pull on SCL while stretching is off. In lossless mode the bench reads late and checks that SCL was held low meanwhile and that both bytes arrive intact. Dropping `enable` with a byte pending shows whether the flags and the word are really cleared.

// File: rtl/i2c_watch_pkg.sv
package i2c_watch_pkg;

   // Events decoded from one pair of successive bus samples
   typedef struct packed {
      logic start;
      logic stop;
      logic scl_rise;
   } bus_evt_t;

   // Tag bits: [0] first byte after start on idle bus, [1] after repeated start
   typedef enum logic [1:0] {
      TAG_NONE   = 2'b00,
      TAG_START  = 2'b01,
      TAG_RSTART = 2'b10
   } cond_tag_t;

   localparam int TAG_W = 2;
   localparam int EXTRA_W = TAG_W + 1;   // tags plus ack level

endpackage

// File: rtl/i2c_watch_cond.sv
module i2c_watch_cond
   import i2c_watch_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     enable,
   input  logic     scl_in,
   input  logic     sda_in,
   output bus_evt_t evt,
   output logic     bus_active,
   output logic     is_rstart,
   output logic     idle_evt
);

   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q      <= 1'b1;
         sda_q      <= 1'b1;
         bus_active <= 1'b0;
      end else if (!enable) begin
         scl_q      <= 1'b1;
         sda_q      <= 1'b1;
         bus_active <= 1'b0;
      end else begin
         scl_q <= scl_in;
         sda_q <= sda_in;
         if (evt.start)
            bus_active <= 1'b1;
         else if (evt.stop)
            bus_active <= 1'b0;
      end
   end

   always_comb begin
      evt.start    = enable & scl_q & scl_in & sda_q & ~sda_in;
      evt.stop     = enable & scl_q & scl_in & ~sda_q & sda_in;
      evt.scl_rise = enable & ~scl_q & scl_in;
      is_rstart    = bus_active & evt.start;
      idle_evt     = bus_active & evt.stop;
   end

endmodule

// File: rtl/i2c_watch_frame.sv
module i2c_watch_frame
   import i2c_watch_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  bus_evt_t          evt,
   input  logic              bus_active,
   input  logic              is_rstart,
   input  logic              sda_in,
   output logic              byte_done,
   output logic [BYTE_W-1:0] done_byte,
   output logic              done_nack,
   output cond_tag_t         done_tag
);

   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);

   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] shreg;
   cond_tag_t         tag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt   <= '0;
         shreg     <= '0;
         tag_q     <= TAG_NONE;
         byte_done <= 1'b0;
         done_byte <= '0;
         done_nack <= 1'b0;
         done_tag  <= TAG_NONE;
      end else if (!enable) begin
         bit_cnt   <= '0;
         shreg     <= '0;
         tag_q     <= TAG_NONE;
         byte_done <= 1'b0;
         done_byte <= '0;
         done_nack <= 1'b0;
         done_tag  <= TAG_NONE;
      end else begin
         byte_done <= 1'b0;
         if (evt.start) begin
            bit_cnt <= '0;
            tag_q   <= is_rstart ? TAG_RSTART : TAG_START;
         end else if (evt.stop) begin
            bit_cnt <= '0;
            tag_q   <= TAG_NONE;
         end else if (evt.scl_rise && bus_active) begin
            if (bit_cnt == ACK_SLOT) begin
               byte_done <= 1'b1;
               done_byte <= shreg;
               done_nack <= sda_in;
               done_tag  <= tag_q;
               tag_q     <= TAG_NONE;
               bit_cnt   <= '0;
            end else begin
               shreg   <= {shreg[BYTE_W-2:0], sda_in};
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/i2c_watch_hold.sv
module i2c_watch_hold
   import i2c_watch_pkg::*;
#(
   parameter int BYTE_W       = 8,
   parameter bit STRETCH_IMPL = 1'b1,
   localparam int WORD_W      = BYTE_W + EXTRA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              stretch_en,
   input  logic              scl_in,
   input  logic              byte_done,
   input  logic [BYTE_W-1:0] done_byte,
   input  logic              done_nack,
   input  cond_tag_t         done_tag,
   input  logic              idle_evt,
   input  logic              rd_strobe,
   input  logic              clr_ovr,
   input  logic              clr_idle,
   output logic [WORD_W-1:0] rd_word,
   output logic              ready,
   output logic              overrun,
   output logic              idle_flag,
   output logic              scl_pull_low
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_word   <= '0;
         ready     <= 1'b0;
         overrun   <= 1'b0;
         idle_flag <= 1'b0;
      end else if (!enable) begin
         rd_word   <= '0;
         ready     <= 1'b0;
         overrun   <= 1'b0;
         idle_flag <= 1'b0;
      end else begin
         if (byte_done)
            rd_word <= {done_nack, done_tag, done_byte};
         ready     <= byte_done | (ready & ~rd_strobe);
         overrun   <= (byte_done & ready & ~rd_strobe) | (overrun & ~clr_ovr);
         idle_flag <= idle_evt | (idle_flag & ~clr_idle);
      end
   end

   generate
      if (STRETCH_IMPL) begin : g_stretch
         logic pull_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pull_q <= 1'b0;
            else if (!enable)
               pull_q <= 1'b0;
            else
               pull_q <= stretch_en & ready & ~rd_strobe & (~scl_in | pull_q);
         end
         assign scl_pull_low = pull_q;
      end else begin : g_passive
         logic unused_stretch;
         assign unused_stretch = stretch_en ^ scl_in;
         assign scl_pull_low   = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch
   import i2c_watch_pkg::*;
#(
   parameter int BYTE_W       = 8,
   parameter bit STRETCH_IMPL = 1'b1,
   localparam int WORD_W      = BYTE_W + EXTRA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              stretch_en,
   input  logic              scl_in,
   input  logic              sda_in,
   input  logic              rd_strobe,
   input  logic              clr_idle,
   input  logic              clr_ovr,
   output logic [WORD_W-1:0] rd_word,
   output logic              ready,
   output logic              overrun,
   output logic              bus_active,
   output logic              idle_flag,
   output logic              scl_pull_low
);

   generate
      if (BYTE_W < 2) begin : g_bad_width
         $error("i2c_bus_watch: BYTE_W must be at least 2");
      end
   endgenerate

   bus_evt_t          cond_evt;
   logic              is_rstart;
   logic              idle_evt;
   logic              byte_done;
   logic [BYTE_W-1:0] done_byte;
   logic              done_nack;
   cond_tag_t         done_tag;

   i2c_watch_cond u_cond (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .scl_in     (scl_in),
      .sda_in     (sda_in),
      .evt        (cond_evt),
      .bus_active (bus_active),
      .is_rstart  (is_rstart),
      .idle_evt   (idle_evt)
   );

   i2c_watch_frame #(.BYTE_W(BYTE_W)) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .evt        (cond_evt),
      .bus_active (bus_active),
      .is_rstart  (is_rstart),
      .sda_in     (sda_in),
      .byte_done  (byte_done),
      .done_byte  (done_byte),
      .done_nack  (done_nack),
      .done_tag   (done_tag)
   );

   i2c_watch_hold #(.BYTE_W(BYTE_W), .STRETCH_IMPL(STRETCH_IMPL)) u_hold (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable       (enable),
      .stretch_en   (stretch_en),
      .scl_in       (scl_in),
      .byte_done    (byte_done),
      .done_byte    (done_byte),
      .done_nack    (done_nack),
      .done_tag     (done_tag),
      .idle_evt     (idle_evt),
      .rd_strobe    (rd_strobe),
      .clr_ovr      (clr_ovr),
      .clr_idle     (clr_idle),
      .rd_word      (rd_word),
      .ready        (ready),
      .overrun      (overrun),
      .idle_flag    (idle_flag),
      .scl_pull_low (scl_pull_low)
   );

endmodule

// File: rtl/i2c_bus_watch_chk.sv
module i2c_bus_watch_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       enable,
   input logic       stretch_en,
   input logic       rd_strobe,
   input logic       clr_idle,
   input logic [1:0] tag_bits,
   input logic       ready,
   input logic       overrun,
   input logic       bus_active,
   input logic       idle_flag,
   input logic       scl_pull_low,
   input logic       byte_done,
   input logic       stop_seen
);

   AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      ready && rd_strobe && !byte_done |=> !ready);                                  // R3

   AST_TAG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> $onehot0(tag_bits));                                                 // R9

   AST_NO_PULL_PASSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !stretch_en |=> !scl_pull_low);                                                // R7

   AST_IDLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      idle_flag && !clr_idle && enable |=> idle_flag);                               // R5

   AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !ready && !overrun && !bus_active && !idle_flag && !scl_pull_low); // R8

   AST_STOP_ENDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_seen |=> !bus_active);                                                    // R4

endmodule

bind i2c_bus_watch i2c_bus_watch_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .enable       (enable),
   .stretch_en   (stretch_en),
   .rd_strobe    (rd_strobe),
   .clr_idle     (clr_idle),
   .tag_bits     (rd_word[WORD_W-2 -: 2]),
   .ready        (ready),
   .overrun      (overrun),
   .bus_active   (bus_active),
   .idle_flag    (idle_flag),
   .scl_pull_low (scl_pull_low),
   .byte_done    (byte_done),
   .stop_seen    (cond_evt.stop)
);

// File: tb/tb_i2c_bus_watch.sv
module tb_i2c_bus_watch;

   localparam int H = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic        stretch_en = 1'b0;
   logic        scl_m = 1'b1;
   logic        sda_m = 1'b1;
   logic        rd_strobe = 1'b0;
   logic        clr_idle = 1'b0;
   logic        clr_ovr = 1'b0;
   logic        scl_in;
   logic [10:0] rd_word;
   logic        ready, overrun, bus_active, idle_flag, scl_pull_low;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   assign scl_in = scl_m & ~scl_pull_low;

   i2c_bus_watch dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .stretch_en(stretch_en),
      .scl_in(scl_in), .sda_in(sda_m), .rd_strobe(rd_strobe),
      .clr_idle(clr_idle), .clr_ovr(clr_ovr), .rd_word(rd_word),
      .ready(ready), .overrun(overrun), .bus_active(bus_active),
      .idle_flag(idle_flag), .scl_pull_low(scl_pull_low)
   );

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic wait_h();
      repeat (H) @(negedge clk);
   endtask

   task automatic raise_scl();
      scl_m = 1'b1;
      @(negedge clk);
      while (scl_in == 1'b0) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wait_h();
      raise_scl(); wait_h();
      sda_m = 1'b0; wait_h();
      scl_m = 1'b0; wait_h();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wait_h();
      raise_scl(); wait_h();
      sda_m = 1'b1; wait_h();
   endtask

   task automatic send_bit(input logic b);
      sda_m = b; wait_h();
      raise_scl(); wait_h();
      scl_m = 1'b0; wait_h();
   endtask

   task automatic send_frame(input logic [7:0] b, input logic nack);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      send_bit(nack);
   endtask

   task automatic pulse_rd();
      @(negedge clk) rd_strobe = 1'b1;
      @(negedge clk) rd_strobe = 1'b0;
   endtask

   task automatic t_reset();
      chk("R8 reset ready", ready, 0);
      chk("R8 reset word", rd_word, 0);
      chk("R4 reset active", bus_active, 0);
      chk("R7 reset pull", scl_pull_low, 0);
   endtask

   task automatic t_basic();
      bus_start();
      chk("R4 active after start", bus_active, 1);
      send_frame(8'hA5, 1'b0);
      chk("R3 ready set", ready, 1);
      chk("R1 R2 R9 first byte word", rd_word, 11'h1A5);
      pulse_rd();
      chk("R3 ready cleared by read", ready, 0);
      chk("R3 word kept after read", rd_word, 11'h1A5);
      send_frame(8'h3C, 1'b1);
      chk("R2 R9 nack byte word", rd_word, 11'h43C);
      pulse_rd();
      bus_start();
      chk("R4 still active after repeated start", bus_active, 1);
      send_frame(8'h81, 1'b0);
      chk("R9 repeated start word", rd_word, 11'h281);
      pulse_rd();
   endtask

   task automatic t_idle();
      chk("R5 idle clear before stop", idle_flag, 0);
      bus_stop();
      chk("R4 inactive after stop", bus_active, 0);
      chk("R5 idle set", idle_flag, 1);
      repeat (20) @(negedge clk);
      chk("R5 idle sticky", idle_flag, 1);
      @(negedge clk) clr_idle = 1'b1;
      @(negedge clk) clr_idle = 1'b0;
      chk("R5 idle cleared", idle_flag, 0);
   endtask

   task automatic t_overrun();
      bus_start();
      send_frame(8'h11, 1'b0);
      chk("R6 no overrun yet", overrun, 0);
      send_frame(8'h22, 1'b0);
      chk("R6 overrun set", overrun, 1);
      chk("R6 word replaced", rd_word, 11'h022);
      chk("R7 no pull when stretch off", scl_pull_low, 0);
      @(negedge clk) clr_ovr = 1'b1;
      @(negedge clk) clr_ovr = 1'b0;
      chk("R6 overrun cleared", overrun, 0);
      chk("R6 ready kept by clear", ready, 1);
      pulse_rd();
      bus_stop();
   endtask

   task automatic t_partial();
      bus_start();
      send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
      bus_stop();
      chk("R10 partial frame dropped", ready, 0);
      bus_start();
      send_frame(8'h5A, 1'b0);
      chk("R10 count restarts", rd_word, 11'h15A);
      pulse_rd();
      bus_stop();
   endtask

   task automatic t_stretch();
      stretch_en = 1'b1;
      bus_start();
      send_frame(8'h66, 1'b0);
      fork
         send_frame(8'h77, 1'b0);
         begin
            repeat (60) @(negedge clk);
            chk("R7 pull held while unread", scl_pull_low, 1);
            chk("R7 bus SCL held low", scl_in, 0);
            chk("R7 first byte intact", rd_word, 11'h166);
            pulse_rd();
         end
      join
      chk("R7 second byte ready", ready, 1);
      chk("R7 second byte word", rd_word, 11'h077);
      chk("R7 no overrun in stretch mode", overrun, 0);
   endtask

   task automatic t_disable();
      @(negedge clk) enable = 1'b0;
      repeat (3) @(negedge clk);
      chk("R8 ready cleared", ready, 0);
      chk("R8 active cleared", bus_active, 0);
      chk("R8 word cleared", rd_word, 0);
      chk("R8 pull cleared", scl_pull_low, 0);
      stretch_en = 1'b0;
      enable = 1'b1;
      bus_stop();
      chk("R8 no idle from stop after disable", idle_flag, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      enable = 1'b1;
      repeat (2) @(negedge clk);
      t_basic();
      t_idle();
      t_overrun();
      @(negedge clk) clr_idle = 1'b1;
      @(negedge clk) clr_idle = 1'b0;
      t_partial();
      t_stretch();
      t_disable();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule